// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit operands and delivers a 2N-bit product. It trades speed for area. It does not build a full partial-product array. It handles one multiplier bit per clock cycle, starting from the least significant bit. When that bit is set, it adds the multiplicand into the upper half of a double-width accumulator through an (N+1)-bit adder. It then shifts the accumulator one place to the right, so the next partial product lines up with the next bit position.

The interface is a simple start/done handshake. When start is seen while the unit is idle or finished, the operands are captured and the accumulator is cleared. busy stays high for exactly N cycles. done then rises, and the product stays on its port until the next accepted start. A start that arrives while the unit is computing is dropped.

Top module: `shmul_unit`

## Requirements
- R1: After synchronous reset, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: When `done_o` is high, `product_o` equals the unsigned product of the two operands captured at the accepted start, zero-extended to 2N bits.
- R3: A start is accepted when `start_i` is high at a rising edge while `busy_o` is low. `busy_o` is then high for exactly N cycles. `done_o` rises at the edge where `busy_o` falls, which is N edges after the accepting edge.
- R4: Once `done_o` is high, `done_o` and `product_o` hold their values for as long as `start_i` stays low.
- R5: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes on time with its own product.
- R6: Corner operands give exact results with no lost carry. A zero operand gives 0. All-ones times all-ones gives (2^N-1)^2.
- R7: Operand inputs are sampled only at the accepting edge. Changing them during the computation does not change the result.
- R8: A start accepted while `done_o` is high clears `done_o` at that edge and begins a new operation.
- R9: `busy_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | N | Multiplicand operand |
| mplier_i | input | N | Multiplier operand |
| busy_o | output | 1 | High while the iterations run |
| done_o | output | 1 | High once the product is valid, until the next accepted start |
| product_o | output | 2N | Unsigned 2N-bit product |

## Verification
The multiplier is driven with several kinds of bit patterns, and each one exposes a different class of fault:
- Sparse multipliers such as single set bits show whether each partial product is aligned to the right position.
- Dense all-ones operands stress the carry out of the (N+1)-bit adder, which a narrower adder would lose.
- A zero on either side shows that no stale accumulator contents remain.
- Known small cases (11×7, 11×9) and a batch of random pairs cover general behaviour.

The timing tests check the exact cycle on which done rises. They also check that a start during busy and operand changes during busy do not disturb the result, and that a back-to-back restart from the done state works.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/shmul_ctrl.sv
module shmul_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import shmul_pkg::*;

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  phase_t          phase_q;
  logic [CW-1:0]   cnt_q;

  assign load_o = start_i && (phase_q != PH_RUN);
  assign step_o = (phase_q == PH_RUN);
  assign busy_o = (phase_q == PH_RUN);
  assign done_o = (phase_q == PH_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) phase_q <= PH_DONE;
        end
        default: begin
          if (start_i) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
          end
        end
      endcase
    end
  end

  // Checker-side length counter, independent of cnt_q
  logic [CW:0] run_len_q;
  always_ff @(posedge clk) begin
    if (rst)               run_len_q <= '0;
    else if (busy_o)       run_len_q <= run_len_q + 1'b1;
    else if (load_o)       run_len_q <= '0;
  end

  // R3
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (run_len_q == (CW+1)'(N)));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R5
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && (run_len_q < (CW+1)'(N - 1))) |=> busy_o);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> (busy_o && !done_o));
endmodule

// File: rtl/shmul_datapath.sv
module shmul_datapath #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic [2*N-1:0] product_o
);
  localparam int PW = 2 * N;

  logic [N-1:0]  mc_q;
  logic [N-1:0]  mq_q;
  logic [PW-1:0] acc_q;
  logic [N:0]    addend;
  logic [N:0]    psum;

  // (N+1)-bit adder keeps the carry of every partial sum
  assign addend = mq_q[0] ? {1'b0, mc_q} : '0;
  assign psum   = {1'b0, acc_q[PW-1:N]} + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q  <= '0;
      mq_q  <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      mc_q  <= mcand_i;
      mq_q  <= mplier_i;
      acc_q <= '0;
    end else if (step_i) begin
      acc_q <= {psum, acc_q[N-1:1]};
      mq_q  <= mq_q >> 1;
    end
  end

  assign product_o = acc_q;

  // R7
  mcand_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> $stable(mc_q));

  // R4
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> $stable(acc_q));
endmodule

// File: rtl/shmul_unit.sv
module shmul_unit #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);
  localparam int PW = 2 * N;

  logic load_w;
  logic step_w;

  shmul_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load_w),
    .step_o  (step_w),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  shmul_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_w),
    .step_i    (step_w),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o)
  );

  // Reference operands captured for the product check
  logic [N-1:0] ref_a_q;
  logic [N-1:0] ref_b_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_a_q <= '0;
      ref_b_q <= '0;
    end else if (start_i && !busy_o) begin
      ref_a_q <= mcand_i;
      ref_b_q <= mplier_i;
    end
  end

  // R2
  product_value_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (product_o == (PW'(ref_a_q) * PW'(ref_b_q))));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(product_o)));
endmodule

// File: tb/sim_shmul_unit.sv
module sim_shmul_unit;
  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i;
  logic [N-1:0]  mcand_i;
  logic [N-1:0]  mplier_i;
  logic          busy_o;
  logic          done_o;
  logic [PW-1:0] product_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  shmul_unit #(.N(N)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Launch an operation; returns just after the accepting edge
  task automatic launch(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Full operation with timing and value checks
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    logic [PW-1:0] exp;
    exp = PW'(a) * PW'(b);
    launch(a, b);
    check(busy_o === 1'b1 && done_o === 1'b0, "R3 busy after start", {busy_o, done_o}, 2'b10);
    for (int k = 1; k < N; k++) @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b1, "R3 not done at N-1", {busy_o, done_o}, 2'b10);
    @(negedge clk);
    check(done_o === 1'b1 && busy_o === 1'b0, "R3 done at N", {busy_o, done_o}, 2'b01);
    check(product_o === exp, req, product_o, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; start_i = 1'b0; mcand_i = '0; mplier_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", {busy_o, done_o}, 2'b00);
    check(product_o === '0, "R1 product", product_o, 0);
  endtask

  task automatic t_known();
    run_op(8'd11, 8'd7, "R2 11x7");
    run_op(8'd11, 8'd9, "R2 11x9");
    for (int i = 0; i < N; i++) run_op(8'hA5, 8'(1 << i), "R2 single bit multiplier");
  endtask

  task automatic t_corners();
    run_op('0, 8'hFF, "R6 zero mcand");
    run_op(8'hFF, '0, "R6 zero mplier");
    run_op(8'hFF, 8'hFF, "R6 all ones");
    run_op(8'h80, 8'h80, "R6 top bits");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) run_op(8'($urandom), 8'($urandom), "R2 random");
  endtask

  task automatic t_hold();
    logic [PW-1:0] snap;
    run_op(8'd200, 8'd3, "R2 hold setup");
    snap = product_o;
    mcand_i = 8'h12; mplier_i = 8'h34;
    repeat (6) @(negedge clk);
    check(done_o === 1'b1, "R4 done held", done_o, 1);
    check(product_o === snap, "R4 product held", product_o, snap);
  endtask

  task automatic t_ignore();
    launch(8'd13, 8'd5);
    @(negedge clk);
    mcand_i = 8'hFF; mplier_i = 8'hFF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // accepting edge + 2 edges passed; N-2 more to done
    for (int k = 3; k < N; k++) @(negedge clk);
    check(done_o === 1'b0, "R5 no restart delay", done_o, 0);
    @(negedge clk);
    check(done_o === 1'b1, "R5 done on time", done_o, 1);
    check(product_o === 16'd65, "R5 first product kept", product_o, 65);
  endtask

  task automatic t_operand_change();
    launch(8'd21, 8'd6);
    mcand_i = 8'hEE; mplier_i = 8'h77;
    for (int k = 1; k <= N; k++) @(negedge clk);
    check(done_o === 1'b1 && product_o === 16'd126, "R7 operands latched", product_o, 126);
  endtask

  task automatic t_restart();
    run_op(8'd3, 8'd4, "R2 before restart");
    launch(8'd10, 8'd10);
    check(done_o === 1'b0 && busy_o === 1'b1, "R8 done cleared", {busy_o, done_o}, 2'b10);
    for (int k = 1; k <= N; k++) @(negedge clk);
    check(product_o === 16'd100, "R8 restart product", product_o, 100);
  endtask

  always @(negedge clk)
    if (!rst && busy_o === 1'b1 && done_o === 1'b1) check(1'b0, "R9 exclusive", 2'b11, 2'b00);

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_corners();
    t_random();
    t_hold();
    t_ignore();
    t_operand_change();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule